// File: doc/BRIEF.md
# Pin-Strapped CPU Bus Slave

This block answers a host processor on a strobe-based parallel bus. The host selects the slave with an active-low select and an active-low address strobe, presents a word address and a direction line, and supplies write data with one parity bit per byte. The slave replies with a data-acknowledge line. On reads it also drives the read data and its parity. Tri-state pins are modelled as a value plus an output-enable.

Five shared pins are sampled on every clock while reset is held, and the value sampled last is kept. That value fixes five things:
- the acknowledge polarity;
- the meaning of the direction line;
- whether write parity is checked;
- whether parity is even or odd;
- whether the acknowledge is held or pulsed.

Once reset is released, the same pins become general-purpose I/O. They start as inputs and are steered through a register.

The access target is a 16-word register file. Words 0 to 13 are plain storage. Word 14 controls the general-purpose pins. Word 15 is a read-only status word.

Top module: `cbs_cpu_slave`

## Requirements
- R1: While reset is low, the slave samples `pin_in` on each clock and keeps the last value as its strap set. The bit positions are: bit0 acknowledge polarity, bit1 direction polarity, bit2 parity ignore, bit3 parity sense, bit4 hold mode. After reset the strap set never changes, and status word 15 shows it in bits [12:8].
- R2: With strap bit0 low, the acknowledge is asserted at level 0 and its inactive level is 1. With bit0 high, both levels are reversed.
- R3: With strap bit1 low, `bus_rw` high means read and low means write. With bit1 high, the meaning is reversed.
- R4: An access starts on a rising edge where `bus_cs_n` and `bus_as_n` are both sampled low. Address and direction are taken on that edge. Write data and its parity are taken on the next edge. After that second edge the acknowledge is driven active, and on reads valid data is driven with it.
- R5: In hold mode (strap bit4 high), the active acknowledge, and on reads `bus_rdata_oe` with stable data, stay driven until `bus_cs_n` is sampled high. On the edge after that, both are released.
- R6: In pulse mode (strap bit4 low), the acknowledge is active for exactly one cycle and inactive-but-driven for the next cycle. It is then released (`bus_ack_oe` low). Read data is driven only during the active cycle.
- R7: A new access may start on the edge right after the acknowledge appears, with `bus_cs_n` held low throughout. The acknowledge then drops for one cycle and comes back for the new access.
- R8: For each byte lane, the read parity bit is the XOR of the byte when strap bit3 is high (even parity) and its inverse when bit3 is low (odd parity).
- R9: When checking is enabled (strap bit2 low), a write whose parity on any lane disagrees with the rule of R8 is discarded and sets a sticky error flag in status bit0. Any accepted write to word 15 clears the flag.
- R10: With strap bit2 high, a write with wrong parity is stored, and the error flag stays clear.
- R11: After reset `pin_oe` is all zero. Word 14 bits [4:0] drive `pin_out` and bits [12:8] drive `pin_oe`. Status bits [20:16] show `pin_in` at the time of the read.
- R12: Words 0 to 14 return the last accepted write and reset to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; straps are sampled while it is low |
| bus_cs_n | input | 1 | Chip select, active low |
| bus_as_n | input | 1 | Address strobe, active low, one cycle per access |
| bus_addr | input | 4 | Word address |
| bus_rw | input | 1 | Direction line, meaning set by strap |
| bus_wdata | input | 32 | Write data, taken one edge after the address |
| bus_wpar | input | 4 | Write parity, one bit per byte |
| bus_rdata | output | 32 | Read data value |
| bus_rpar | output | 4 | Read parity, one bit per byte |
| bus_rdata_oe | output | 1 | Read data enable |
| bus_ack | output | 1 | Data-acknowledge value |
| bus_ack_oe | output | 1 | Data-acknowledge enable |
| pin_in | input | 5 | Shared pins: straps during reset, general inputs after |
| pin_out | output | 5 | General-purpose output values |
| pin_oe | output | 5 | General-purpose output enables |

## Verification
Every strap combination changes the wire-level protocol, and a strap can only be changed by another reset. The stimulus therefore runs four reset epochs, each with a different strap pattern, so that both acknowledge polarities, both direction meanings, both parity senses, parity ignore on and off, and both hold and pulse modes are covered.

The hardest case is a back-to-back access where select never drops. It needs the new strobe placed exactly on the edge after the acknowledge appears. Random sequences chain accesses this way, in both acknowledge modes. Within each epoch, randomly addressed writes and reads are mixed with directed bad-parity writes on a random byte lane.

// File: rtl/cbs_pkg.sv
package cbs_pkg;

  localparam int unsigned STRAP_W = 5;
  localparam int unsigned LANE_W  = 8;

  typedef struct packed {
    logic hold;
    logic par_even;
    logic par_ignore;
    logic rw_inv;
    logic ack_high;
  } strap_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DATA = 2'd1,
    ST_ACK  = 2'd2,
    ST_NEG  = 2'd3
  } bus_st_e;

  function automatic logic lane_parity(input logic [LANE_W-1:0] b, input logic even);
    logic x;
    x = ^b;
    return even ? x : ~x;
  endfunction

  function automatic logic dir_is_read(input logic rw, input logic rw_inv);
    return rw_inv ? ~rw : rw;
  endfunction

endpackage

// File: rtl/cbs_strap_latch.sv
module cbs_strap_latch #(
  parameter int unsigned GPIO_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [GPIO_W-1:0] pins_i,
  output cbs_pkg::strap_t   strap_o
);
  import cbs_pkg::*;

  strap_t strap_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      strap_q <= strap_t'(pins_i[STRAP_W-1:0]);
    end
  end

  assign strap_o = strap_q;

endmodule

// File: rtl/cbs_lane_parity.sv
module cbs_lane_parity #(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0]                   data_i,
  input  logic                                even_i,
  output logic [DATA_W/cbs_pkg::LANE_W-1:0]   par_o
);
  import cbs_pkg::*;

  localparam int unsigned NLANE = DATA_W / LANE_W;

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    assign par_o[g] = lane_parity(data_i[g*LANE_W +: LANE_W], even_i);
  end

endmodule

// File: rtl/cbs_bus_fsm.sv
module cbs_bus_fsm #(
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ack_high_i,
  input  logic              rw_inv_i,
  input  logic              hold_i,
  input  logic              cs_n_i,
  input  logic              as_n_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rw_i,
  output logic              acc_fire_o,
  output logic              acc_read_o,
  output logic [ADDR_W-1:0] acc_addr_o,
  output logic              ack_active_o,
  output logic              neg_phase_o,
  output logic              ack_o,
  output logic              ack_oe_o,
  output logic              rdata_oe_o
);
  import cbs_pkg::*;

  bus_st_e           st_q;
  logic              rd_q;
  logic [ADDR_W-1:0] addr_q;
  logic              start;

  assign start = !cs_n_i && !as_n_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      rd_q   <= 1'b0;
      addr_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start) st_q <= ST_DATA;
        ST_DATA: st_q <= ST_ACK;
        ST_ACK: begin
          if (start)       st_q <= ST_DATA;
          else if (!hold_i) st_q <= ST_NEG;
          else if (cs_n_i)  st_q <= ST_IDLE;
        end
        ST_NEG: st_q <= start ? ST_DATA : ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
      if (start && st_q != ST_DATA) begin
        rd_q   <= dir_is_read(rw_i, rw_inv_i);
        addr_q <= addr_i;
      end
    end
  end

  assign acc_fire_o   = (st_q == ST_DATA);
  assign acc_read_o   = rd_q;
  assign acc_addr_o   = addr_q;
  assign ack_active_o = (st_q == ST_ACK);
  assign neg_phase_o  = (st_q == ST_NEG);
  assign ack_oe_o     = ack_active_o || neg_phase_o;
  assign ack_o        = ack_active_o ? ack_high_i : ~ack_high_i;
  assign rdata_oe_o   = ack_active_o && rd_q;

endmodule

// File: rtl/cbs_regfile.sv
module cbs_regfile #(
  parameter int unsigned ADDR_W  = 4,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned GPIO_W  = 5,
  parameter int unsigned STRAP_W = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en_i,
  input  logic               rd_en_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic               par_err_i,
  input  logic [STRAP_W-1:0] straps_i,
  input  logic [GPIO_W-1:0]  gpio_in_i,
  output logic [DATA_W-1:0]  rdata_o,
  output logic               sticky_o,
  output logic [GPIO_W-1:0]  gpio_out_o,
  output logic [GPIO_W-1:0]  gpio_oe_o
);
  localparam int unsigned DEPTH      = 1 << ADDR_W;
  localparam int unsigned STORE_N    = DEPTH - 1;
  localparam int unsigned STATUS_IDX = DEPTH - 1;
  localparam int unsigned GPIO_IDX   = DEPTH - 2;
  localparam int unsigned OE_LSB     = 8;
  localparam int unsigned STRAP_LSB  = 8;
  localparam int unsigned PIN_LSB    = 16;

  logic [DATA_W-1:0] mem_q [STORE_N];
  logic [DATA_W-1:0] rd_mux;
  logic [DATA_W-1:0] rdata_q;
  logic              sticky_q;
  logic              hit_status;

  function automatic logic [DATA_W-1:0] status_word(
    input logic [STRAP_W-1:0] s, input logic [GPIO_W-1:0] p, input logic e);
    logic [DATA_W-1:0] w;
    w = '0;
    w[0] = e;
    w[STRAP_LSB +: STRAP_W] = s;
    w[PIN_LSB +: GPIO_W] = p;
    return w;
  endfunction

  assign hit_status = (addr_i == ADDR_W'(STATUS_IDX));

  always_comb begin
    rd_mux = status_word(straps_i, gpio_in_i, sticky_q);
    for (int i = 0; i < STORE_N; i++) begin
      if (addr_i == ADDR_W'(i)) rd_mux = mem_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STORE_N; i++) mem_q[i] <= '0;
      sticky_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      for (int i = 0; i < STORE_N; i++) begin
        if (wr_en_i && addr_i == ADDR_W'(i)) mem_q[i] <= wdata_i;
      end
      if (par_err_i)                 sticky_q <= 1'b1;
      else if (wr_en_i && hit_status) sticky_q <= 1'b0;
      if (rd_en_i) rdata_q <= rd_mux;
    end
  end

  assign rdata_o    = rdata_q;
  assign sticky_o   = sticky_q;
  assign gpio_out_o = mem_q[GPIO_IDX][GPIO_W-1:0];
  assign gpio_oe_o  = mem_q[GPIO_IDX][OE_LSB +: GPIO_W];

endmodule

// File: rtl/cbs_cpu_slave.sv
module cbs_cpu_slave #(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned GPIO_W = 5
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               bus_cs_n,
  input  logic                               bus_as_n,
  input  logic [ADDR_W-1:0]                  bus_addr,
  input  logic                               bus_rw,
  input  logic [DATA_W-1:0]                  bus_wdata,
  input  logic [DATA_W/cbs_pkg::LANE_W-1:0]  bus_wpar,
  output logic [DATA_W-1:0]                  bus_rdata,
  output logic [DATA_W/cbs_pkg::LANE_W-1:0]  bus_rpar,
  output logic                               bus_rdata_oe,
  output logic                               bus_ack,
  output logic                               bus_ack_oe,
  input  logic [GPIO_W-1:0]                  pin_in,
  output logic [GPIO_W-1:0]                  pin_out,
  output logic [GPIO_W-1:0]                  pin_oe
);
  import cbs_pkg::*;

  localparam int unsigned NLANE = DATA_W / LANE_W;

  strap_t              strap_q;
  logic [STRAP_W-1:0]  strap_bits;
  logic                acc_fire;
  logic                acc_read;
  logic [ADDR_W-1:0]   acc_addr;
  logic                ack_active;
  logic                neg_phase;
  logic [NLANE-1:0]    wpar_exp;
  logic                par_bad;
  logic                par_err_evt;
  logic                wr_commit;
  logic                par_sticky;

  cbs_strap_latch #(.GPIO_W(GPIO_W)) u_strap (
    .clk(clk), .rst_n(rst_n), .pins_i(pin_in), .strap_o(strap_q)
  );

  assign strap_bits = strap_q;

  cbs_bus_fsm #(.ADDR_W(ADDR_W)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .ack_high_i(strap_q.ack_high), .rw_inv_i(strap_q.rw_inv), .hold_i(strap_q.hold),
    .cs_n_i(bus_cs_n), .as_n_i(bus_as_n), .addr_i(bus_addr), .rw_i(bus_rw),
    .acc_fire_o(acc_fire), .acc_read_o(acc_read), .acc_addr_o(acc_addr),
    .ack_active_o(ack_active), .neg_phase_o(neg_phase),
    .ack_o(bus_ack), .ack_oe_o(bus_ack_oe), .rdata_oe_o(bus_rdata_oe)
  );

  cbs_lane_parity #(.DATA_W(DATA_W)) u_wpar (
    .data_i(bus_wdata), .even_i(strap_q.par_even), .par_o(wpar_exp)
  );

  assign par_bad     = |(wpar_exp ^ bus_wpar);
  assign par_err_evt = acc_fire && !acc_read && !strap_q.par_ignore && par_bad;
  assign wr_commit   = acc_fire && !acc_read && !par_err_evt;

  cbs_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .GPIO_W(GPIO_W), .STRAP_W(STRAP_W)) u_rf (
    .clk(clk), .rst_n(rst_n),
    .wr_en_i(wr_commit), .rd_en_i(acc_fire && acc_read), .addr_i(acc_addr),
    .wdata_i(bus_wdata), .par_err_i(par_err_evt), .straps_i(strap_bits),
    .gpio_in_i(pin_in), .rdata_o(bus_rdata), .sticky_o(par_sticky),
    .gpio_out_o(pin_out), .gpio_oe_o(pin_oe)
  );

  cbs_lane_parity #(.DATA_W(DATA_W)) u_rpar (
    .data_i(bus_rdata), .even_i(strap_q.par_even), .par_o(bus_rpar)
  );

endmodule

// File: rtl/cbs_cpu_slave_chk.sv
module cbs_cpu_slave_chk #(
  parameter int unsigned GPIO_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic [4:0]        strap,
  input logic              acc_fire,
  input logic              ack_active,
  input logic              neg_phase,
  input logic              par_err_evt,
  input logic              sticky,
  input logic              ack,
  input logic              ack_oe,
  input logic              rdata_oe,
  input logic [GPIO_W-1:0] gpio_oe
);

  AST_STRAP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $stable(strap)); // R1

  AST_DATA_THEN_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    acc_fire |=> ack_active); // R4

  AST_READ_DATA_ACKED: assert property (@(posedge clk) disable iff (!rst_n)
    rdata_oe |-> (ack_oe && ack == strap[0])); // R5

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_active && !strap[4]) |=> !ack_active); // R6

  AST_NEG_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    neg_phase |=> !neg_phase); // R6

  AST_PAR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    par_err_evt |=> sticky); // R9

  AST_GPIO_INPUT_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (gpio_oe == '0)); // R11

endmodule

bind cbs_cpu_slave cbs_cpu_slave_chk #(.GPIO_W(GPIO_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .strap(strap_bits), .acc_fire(acc_fire),
  .ack_active(ack_active), .neg_phase(neg_phase), .par_err_evt(par_err_evt),
  .sticky(par_sticky), .ack(bus_ack), .ack_oe(bus_ack_oe),
  .rdata_oe(bus_rdata_oe), .gpio_oe(pin_oe)
);

// File: tb/cbs_cpu_slave_tb.sv
module cbs_cpu_slave_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1, as_n = 1'b1, rw = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [3:0]  wpar = '0;
  logic [31:0] rdata;
  logic [3:0]  rpar;
  logic        rdata_oe, ack, ack_oe;
  logic [4:0]  pin_in = '0;
  logic [4:0]  pin_out, pin_oe;

  int errors = 0;
  int checks = 0;

  logic [31:0] model [15];
  logic        m_sticky;
  logic [4:0]  cfg;

  always #4 clk = ~clk;

  cbs_cpu_slave dut_i (
    .clk(clk), .rst_n(rst_n), .bus_cs_n(cs_n), .bus_as_n(as_n), .bus_addr(addr),
    .bus_rw(rw), .bus_wdata(wdata), .bus_wpar(wpar), .bus_rdata(rdata),
    .bus_rpar(rpar), .bus_rdata_oe(rdata_oe), .bus_ack(ack), .bus_ack_oe(ack_oe),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  function automatic logic [3:0] exp_par(input logic [31:0] d, input logic even);
    logic [3:0] p;
    for (int i = 0; i < 4; i++) begin
      p[i] = 1'b0;
      for (int b = 0; b < 8; b++) p[i] = p[i] ^ d[i*8+b];
      if (!even) p[i] = ~p[i];
    end
    return p;
  endfunction

  function automatic logic [31:0] exp_word(input int a);
    if (a == 15) return {11'b0, pin_in, 3'b0, cfg, 7'b0, m_sticky};
    return model[a];
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  task automatic step;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic apply_reset(input logic [4:0] c);
    @(negedge clk);
    rst_n = 1'b0;
    cs_n = 1'b1; as_n = 1'b1;
    pin_in = c;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    cfg = c;
    m_sticky = 1'b0;
    for (int i = 0; i < 15; i++) model[i] = '0;
    #1;
    chk("R11", "pin_oe after reset", 32'(pin_oe), 32'h0);
    chk("R5", "ack_oe after reset", 32'(ack_oe), 32'h0);
    chk("R5", "rdata_oe after reset", 32'(rdata_oe), 32'h0);
    pin_in = ~c ^ 5'($urandom);
  endtask

  // One access; starts at a negedge, ends at a negedge.
  task automatic access(input bit is_rd, input int a, input logic [31:0] d,
                        input logic [3:0] bad, input bit b2b);
    logic act_lvl;
    logic [31:0] expd;
    act_lvl = cfg[0];
    cs_n = 1'b0; as_n = 1'b0;
    addr = 4'(a);
    rw = is_rd ^ cfg[1];
    wdata = ~d; wpar = 4'($urandom);
    step();
    as_n = 1'b1;
    addr = 4'($urandom); rw = ~rw;
    wdata = d; wpar = exp_par(d, cfg[3]) ^ bad;
    chk("R4", "ack_oe during data phase", 32'(ack_oe), 32'h0);
    step();
    wdata = 32'($urandom); wpar = 4'($urandom);
    chk("R4", "ack_oe after data edge", 32'(ack_oe), 32'h1);
    chk("R2", "ack active level", 32'(ack), 32'(act_lvl));
    if (is_rd) begin
      expd = exp_word(a);
      chk("R3 R12", "read data", rdata, expd);
      chk("R8", "read parity", 32'(rpar), 32'(exp_par(expd, cfg[3])));
      chk("R4", "rdata_oe on read", 32'(rdata_oe), 32'h1);
    end else begin
      chk("R3", "rdata_oe on write", 32'(rdata_oe), 32'h0);
      if (bad != 0 && !cfg[2]) m_sticky = 1'b1;
      else if (a == 15) m_sticky = 1'b0;
      else model[a] = d;
    end
    if (b2b) return;
    if (cfg[4]) begin
      for (int k = 0; k < 2; k++) begin
        step();
        chk("R5", "ack held", 32'(ack_oe && ack == act_lvl), 32'h1);
        if (is_rd) chk("R5", "read data held", {rdata_oe, rdata[30:0]}, {1'b1, expd[30:0]});
      end
      cs_n = 1'b1;
      step();
      chk("R5", "ack released after select drop", 32'(ack_oe), 32'h0);
      chk("R5", "rdata released", 32'(rdata_oe), 32'h0);
    end else begin
      cs_n = 1'b1;
      step();
      chk("R6", "ack driven inactive", {30'b0, ack_oe, ack}, {30'b0, 1'b1, ~act_lvl});
      chk("R6", "rdata off in inactive cycle", 32'(rdata_oe), 32'h0);
      step();
      chk("R6", "ack released", 32'(ack_oe), 32'h0);
    end
  endtask

  task automatic run_epoch(input logic [4:0] c);
    int n;
    logic [31:0] d;
    logic [3:0] lane;
    apply_reset(c);
    access(1'b1, 15, 0, 0, 1'b0);            // R1 strap readback, R11 pins
    n = 12;
    for (int i = 0; i < n; i++) begin
      access(1'b0, int'($urandom % 14), $urandom, 0, (i != n-1) && $urandom % 2 == 1); // R7
    end
    for (int a = 0; a < 14; a++) begin
      access(1'b1, a, 0, 0, (a != 13) && $urandom % 2 == 1); // R7 R12
    end
    d = $urandom;
    lane = 4'b0001 << ($urandom % 4);
    access(1'b0, 3, d, lane, 1'b0);          // R9 / R10
    access(1'b1, 3, 0, 0, 1'b0);
    access(1'b1, 15, 0, 0, 1'b0);
    access(1'b0, 15, $urandom, 0, 1'b1);     // clears flag, R9
    access(1'b1, 15, 0, 0, 1'b0);
    d = $urandom;
    access(1'b0, 14, d, 0, 1'b0);            // R11
    chk("R11", "pin_out", 32'(pin_out), 32'(d[4:0]));
    chk("R11", "pin_oe", 32'(pin_oe), 32'(d[12:8]));
    access(1'b1, 14, 0, 0, 1'b0);
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    run_epoch(5'b11000); // hold, even, check, rw normal, ack low
    run_epoch(5'b00011); // pulse, odd, check, rw inverted, ack high
    run_epoch(5'b10110); // hold, odd, ignore, rw inverted, ack low
    run_epoch(5'b01101); // pulse, even, ignore, rw normal, ack high
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R4 watchdog act=hung exp=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule